// File: doc/BRIEF.md
# Indirect Register Access Port

This block sits between a byte-wide host bus and a bank of thirty-two internal byte registers. The host sees only two bus locations. Location 0 holds the index of the register to reach, and reading it returns the live auxiliary status byte. Location 1 is a window onto whichever register that index selects. After each window access the index moves forward by one, so the host can walk a run of registers without reloading it. The index stays put on the command, data and auxiliary status registers, so repeated accesses keep landing on them.

Some accesses have side effects that the block produces itself. Writing the command register marks a command as in progress and starts the command unit. Reading the status register clears the pending interrupt. Writing the first command-descriptor byte clears the command-phase register. Command execution and data movement stay outside the block. The block reaches them through single-cycle strobes, and a completion strobe brings results back.

Top module: `regsel_port`

## Requirements
- R1: After reset the index, every register, the interrupt-pending and command-in-progress flags, `busRdata`, `irqOut` and all output strobes are zero.
- R2: A write to location 0 loads the index with bits 4:0 of `busWdata`. Bits 7:5 are ignored.
- R3: A write to location 1 stores `busWdata` in the indexed register. A read of location 1 puts that register's value on `busRdata` in the cycle after the read strobe, and the value holds until the next read.
- R4: After a location-1 read or write the index steps by one, modulo 32. The exception is an index of 0x18 (command), 0x19 (data) or 0x1F (auxiliary status), where it stays.
- R5: A read of location 0 returns the auxiliary status byte and changes nothing. Bit 7 is interrupt pending, bit 6 is `unitFlags[3]` (last command ignored), bit 5 is `unitFlags[2]` (busy), bit 4 is command in progress, bit 1 is `unitFlags[1]` (parity error), bit 0 is `unitFlags[0]` (buffer ready), and bits 3:2 read as zero.
- R6: A `doneStb` cycle loads `doneStatus` into register 0x17, sets interrupt pending and clears command in progress. `irqOut` goes high in the next cycle.
- R7: A location-1 read at index 0x17 clears interrupt pending, and `irqOut` is low in the next cycle. If `doneStb` falls in the same cycle, the interrupt stays set and the read returns the old status.
- R8: A location-1 write at index 0x18 sets command in progress. `cmdStart` pulses for one cycle in the next cycle, with `cmdCode` already showing the written byte.
- R9: A location-1 write at index 0x03 also clears register 0x10.
- R10: Location-1 writes at index 0x1F are ignored. Location-1 reads at index 0x1F return the auxiliary status byte.
- R11: Accesses to bus offsets 2 and 3 are ignored on write, leave the index alone, and return 0x00 on read.
- R12: A location-1 write or read at index 0x19 gives a one-cycle `dataWrPulse` or `dataRdPulse` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Single-cycle write strobe |
| busRe | input | 1 | Single-cycle read strobe |
| busAddr | input | 2 | Bus offset (0 = index/aux, 1 = window) |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| irqOut | output | 1 | Interrupt request, follows interrupt pending |
| unitFlags | input | 4 | Live flags from command unit: ignored, busy, parity, buffer ready |
| doneStb | input | 1 | Command completion strobe |
| doneStatus | input | 8 | Completion status byte |
| cmdStart | output | 1 | One-cycle command start pulse |
| cmdCode | output | 8 | Contents of the command register |
| dataWrPulse | output | 1 | Data register was written |
| dataRdPulse | output | 1 | Data register was read |

## Verification
The assertions assume that `busWe` and `busRe` are never high in the same cycle, and that every strobe lasts exactly one clock. The bench drives each access from a task that raises one strobe for a single cycle and then drops it, so the two never overlap. Completion strobes are issued alone, except in one test that deliberately places a completion in the same cycle as a status read to check which takes priority. The unit flags change only while the bus is idle, so each status read sees stable flags.

// File: rtl/regsel_port_pkg.sv
package regsel_port_pkg;
  localparam int IDX_CDB1   = 'h03;
  localparam int IDX_PHASE  = 'h10;
  localparam int IDX_STATUS = 'h17;
  localparam int IDX_CMD    = 'h18;
  localparam int IDX_DATA   = 'h19;
  localparam int IDX_AUX    = 'h1F;

  typedef struct packed {
    logic selLoad;
    logic auxRd;
    logic regWr;
    logic regRd;
    logic zeroRd;
    logic stepSel;
    logic cmdGo;
    logic phaseClr;
    logic intClr;
    logic dataWr;
    logic dataRd;
  } portStrobes_t;
endpackage

// File: rtl/regsel_port_ctrl.sv
module regsel_port_ctrl
  import regsel_port_pkg::*;
#(
  parameter int SEL_W  = 5,
  parameter int BUS_AW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [SEL_W-1:0]  sel,
  output portStrobes_t      st
);
  logic atIdx, atWin, special;

  always_comb begin
    atIdx   = (busAddr == BUS_AW'(0));
    atWin   = (busAddr == BUS_AW'(1));
    special = (sel == SEL_W'(IDX_CMD)) || (sel == SEL_W'(IDX_DATA)) ||
              (sel == SEL_W'(IDX_AUX));
    st          = '0;
    st.selLoad  = busWe && atIdx;
    st.auxRd    = busRe && atIdx;
    st.regWr    = busWe && atWin;
    st.regRd    = busRe && atWin;
    st.zeroRd   = busRe && !atIdx && !atWin;
    st.stepSel  = (busWe || busRe) && atWin && !special;
    st.cmdGo    = st.regWr && (sel == SEL_W'(IDX_CMD));
    st.phaseClr = st.regWr && (sel == SEL_W'(IDX_CDB1));
    st.intClr   = st.regRd && (sel == SEL_W'(IDX_STATUS));
    st.dataWr   = st.regWr && (sel == SEL_W'(IDX_DATA));
    st.dataRd   = st.regRd && (sel == SEL_W'(IDX_DATA));
  end

  // Input assumption: the bus never reads and writes in one cycle.
  p_bus_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && busRe));
endmodule

// File: rtl/regsel_port_dpath.sv
module regsel_port_dpath
  import regsel_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobes_t      st,
  input  logic [DATA_W-1:0] wdata,
  input  logic [3:0]        unitFlags,
  input  logic              doneStb,
  input  logic [DATA_W-1:0] doneStatus,
  output logic [SEL_W-1:0]  sel,
  output logic [DATA_W-1:0] rdata,
  output logic              intP,
  output logic              cmdStart,
  output logic [DATA_W-1:0] cmdCode,
  output logic              dataWrPulse,
  output logic              dataRdPulse
);
  localparam int NREG = 1 << SEL_W;

  logic [DATA_W-1:0] regFile [NREG];
  logic              cip;
  logic [DATA_W-1:0] auxByte;

  assign auxByte = DATA_W'({intP, unitFlags[3], unitFlags[2], cip, 2'b00,
                            unitFlags[1], unitFlags[0]});
  assign cmdCode = regFile[IDX_CMD];

  // Index register
  always_ff @(posedge clk) begin
    if (!rstN)           sel <= '0;
    else if (st.selLoad) sel <= wdata[SEL_W-1:0];
    else if (st.stepSel) sel <= sel + SEL_W'(1);
  end

  // Register bank; the aux slot is never written through the window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regFile[i] <= '0;
    end else begin
      if (st.regWr && sel != SEL_W'(IDX_AUX)) regFile[sel] <= wdata;
      if (st.phaseClr) regFile[IDX_PHASE] <= '0;
      if (doneStb)     regFile[IDX_STATUS] <= doneStatus;
    end
  end

  // Flags: completion beats status-read clear; a new command beats completion
  always_ff @(posedge clk) begin
    if (!rstN) begin
      intP <= 1'b0;
      cip  <= 1'b0;
    end else begin
      if (doneStb)        intP <= 1'b1;
      else if (st.intClr) intP <= 1'b0;
      if (st.cmdGo)       cip <= 1'b1;
      else if (doneStb)   cip <= 1'b0;
    end
  end

  // Read data and outgoing strobes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdata       <= '0;
      cmdStart    <= 1'b0;
      dataWrPulse <= 1'b0;
      dataRdPulse <= 1'b0;
    end else begin
      if (st.zeroRd)     rdata <= '0;
      else if (st.auxRd) rdata <= auxByte;
      else if (st.regRd) rdata <= (sel == SEL_W'(IDX_AUX)) ? auxByte : regFile[sel];
      cmdStart    <= st.cmdGo;
      dataWrPulse <= st.dataWr;
      dataRdPulse <= st.dataRd;
    end
  end

  p_sel_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    st.selLoad |=> sel == $past(wdata[SEL_W-1:0]));
  p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (st.regWr || st.regRd) && !st.selLoad &&
    (sel == SEL_W'(IDX_CMD) || sel == SEL_W'(IDX_DATA) || sel == SEL_W'(IDX_AUX))
    |=> $stable(sel));
  p_done_sets_int_r6: assert property (@(posedge clk) disable iff (!rstN)
    doneStb && !st.cmdGo |=> intP && !cip);
  p_status_read_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.intClr && !doneStb |=> !intP);
  p_cmd_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    st.cmdGo |=> cmdStart && cip);
  p_phase_cleared_r9: assert property (@(posedge clk) disable iff (!rstN)
    st.phaseClr |=> regFile[IDX_PHASE] == '0);
  p_aux_readonly_r10: assert property (@(posedge clk) disable iff (!rstN)
    st.regWr && sel == SEL_W'(IDX_AUX) && !doneStb |=> $stable(intP) && $stable(cip));
  p_bad_offset_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    st.zeroRd |=> rdata == '0);
endmodule

// File: rtl/regsel_port.sv
module regsel_port
  import regsel_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 5,
  parameter int BUS_AW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  input  logic [3:0]        unitFlags,
  input  logic              doneStb,
  input  logic [DATA_W-1:0] doneStatus,
  output logic              cmdStart,
  output logic [DATA_W-1:0] cmdCode,
  output logic              dataWrPulse,
  output logic              dataRdPulse
);
  portStrobes_t     st;
  logic [SEL_W-1:0] sel;

  regsel_port_ctrl #(.SEL_W(SEL_W), .BUS_AW(BUS_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe),
    .busAddr(busAddr), .sel(sel), .st(st)
  );

  regsel_port_dpath #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .wdata(busWdata),
    .unitFlags(unitFlags), .doneStb(doneStb), .doneStatus(doneStatus),
    .sel(sel), .rdata(busRdata), .intP(irqOut), .cmdStart(cmdStart),
    .cmdCode(cmdCode), .dataWrPulse(dataWrPulse), .dataRdPulse(dataRdPulse)
  );
endmodule

// File: tb/regsel_port_bench.sv
module regsel_port_bench;
  logic       clk = 1'b0;
  logic       rstN;
  logic       busWe, busRe;
  logic [1:0] busAddr;
  logic [7:0] busWdata, busRdata;
  logic       irqOut;
  logic [3:0] unitFlags;
  logic       doneStb;
  logic [7:0] doneStatus;
  logic       cmdStart;
  logic [7:0] cmdCode;
  logic       dataWrPulse, dataRdPulse;

  int  errCount = 0;
  int  chkCount = 0;
  bit  finished = 0;

  always #10 clk = ~clk;

  regsel_port u_regsel_port (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut),
    .unitFlags(unitFlags), .doneStb(doneStb), .doneStatus(doneStatus),
    .cmdStart(cmdStart), .cmdCode(cmdCode), .dataWrPulse(dataWrPulse),
    .dataRdPulse(dataRdPulse)
  );

  // {isRead, offset, writeData, expectedRead}
  localparam int NVEC = 17;
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 8'h05, 8'h00},
    {1'b0, 2'd1, 8'hA1, 8'h00},
    {1'b0, 2'd1, 8'hB2, 8'h00},
    {1'b0, 2'd1, 8'hC3, 8'h00},
    {1'b0, 2'd0, 8'h05, 8'h00},
    {1'b1, 2'd1, 8'h00, 8'hA1},
    {1'b1, 2'd1, 8'h00, 8'hB2},
    {1'b1, 2'd1, 8'h00, 8'hC3},
    {1'b0, 2'd0, 8'hE9, 8'h00},
    {1'b0, 2'd1, 8'h5A, 8'h00},
    {1'b0, 2'd0, 8'h09, 8'h00},
    {1'b1, 2'd1, 8'h00, 8'h5A},
    {1'b0, 2'd0, 8'h1E, 8'h00},
    {1'b0, 2'd1, 8'h66, 8'h00},
    {1'b1, 2'd1, 8'h00, 8'h00},
    {1'b0, 2'd0, 8'h1E, 8'h00},
    {1'b1, 2'd1, 8'h00, 8'h66}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    chkCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    busAddr = a; busRe = 1'b1;
    @(negedge clk);
    busRe = 1'b0;
    d = busRdata;
  endtask

  task automatic done(input logic [7:0] s);
    doneStatus = s; doneStb = 1'b1;
    @(negedge clk);
    doneStb = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errCount++; chkCount++;
      $display("FAIL watchdog: actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("Result: errors=%0d of %0d checks", errCount, chkCount);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rstN = 1'b0; busWe = 0; busRe = 0; busAddr = 0; busWdata = 0;
    unitFlags = 0; doneStb = 0; doneStatus = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdata", busRdata, 8'h00);
    chk("R1 irqOut", {7'd0, irqOut}, 8'h00);
    chk("R1 cmdStart", {7'd0, cmdStart}, 8'h00);
    rd(2'd0, v); chk("R1 aux", v, 8'h00);
    rd(2'd1, v); chk("R1 reg0", v, 8'h00);

    // R2 R3 R4 vector walk
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][18]) begin
        rd(VEC[i][17:16], v);
        chk($sformatf("R3/R4/R2 vector %0d", i), v, VEC[i][7:0]);
      end else begin
        wr(VEC[i][17:16], VEC[i][15:8]);
      end
    end

    // R8 command write, R4 hold at 0x18
    wr(2'd0, 8'h18);
    wr(2'd1, 8'h07);
    chk("R8 cmdStart", {7'd0, cmdStart}, 8'h01);
    chk("R8 cmdCode", cmdCode, 8'h07);
    @(negedge clk);
    chk("R8 cmdStart one cycle", {7'd0, cmdStart}, 8'h00);
    rd(2'd0, v); chk("R8 cip in aux", v, 8'h10);
    wr(2'd1, 8'h09);
    chk("R4 index held on 0x18", cmdCode, 8'h09);

    // R12 data register pulses, R4 hold at 0x19
    wr(2'd0, 8'h19);
    wr(2'd1, 8'h3C);
    chk("R12 dataWrPulse", {7'd0, dataWrPulse}, 8'h01);
    rd(2'd1, v); chk("R12 data read", v, 8'h3C);
    chk("R12 dataRdPulse", {7'd0, dataRdPulse}, 8'h01);
    rd(2'd1, v); chk("R4 index held on 0x19", v, 8'h3C);

    // R6 completion, R5 aux layout and no side effects
    done(8'h85);
    chk("R6 irqOut", {7'd0, irqOut}, 8'h01);
    rd(2'd0, v); chk("R6 aux int set cip clear", v, 8'h80);
    rd(2'd0, v); chk("R5 aux read repeat", v, 8'h80);
    chk("R5 irq kept", {7'd0, irqOut}, 8'h01);
    unitFlags = 4'hF;
    rd(2'd0, v); chk("R5 bit layout", v, 8'hE3);
    unitFlags = 4'h0;

    // R10 aux through window
    wr(2'd0, 8'h1F);
    wr(2'd1, 8'hFF);
    rd(2'd0, v); chk("R10 write ignored", v, 8'h80);
    rd(2'd1, v); chk("R10 window reads aux", v, 8'h80);

    // R7 status read clears interrupt; R4 step 0x17 -> 0x18
    wr(2'd0, 8'h17);
    rd(2'd1, v); chk("R7 status value", v, 8'h85);
    chk("R7 irq cleared", {7'd0, irqOut}, 8'h00);
    wr(2'd1, 8'h0C);
    chk("R4 step from 0x17", cmdCode, 8'h0C);
    chk("R4 step cmdStart", {7'd0, cmdStart}, 8'h01);

    // R7 completion wins over same-cycle status read
    done(8'h85);
    wr(2'd0, 8'h17);
    busAddr = 2'd1; busRe = 1'b1; doneStatus = 8'h42; doneStb = 1'b1;
    @(negedge clk);
    busRe = 1'b0; doneStb = 1'b0;
    chk("R7 same-cycle old status", busRdata, 8'h85);
    chk("R7 completion wins", {7'd0, irqOut}, 8'h01);
    wr(2'd0, 8'h17);
    rd(2'd1, v); chk("R7 new status", v, 8'h42);
    chk("R7 irq cleared again", {7'd0, irqOut}, 8'h00);

    // R9 first descriptor byte clears phase register
    wr(2'd0, 8'h10); wr(2'd1, 8'h55);
    wr(2'd0, 8'h10); rd(2'd1, v); chk("R9 phase written", v, 8'h55);
    wr(2'd0, 8'h03); wr(2'd1, 8'h12);
    wr(2'd0, 8'h10); rd(2'd1, v); chk("R9 phase cleared", v, 8'h00);
    wr(2'd0, 8'h03); rd(2'd1, v); chk("R9 cdb stored", v, 8'h12);

    // R11 invalid offsets
    wr(2'd0, 8'h05);
    wr(2'd2, 8'h1F);
    wr(2'd3, 8'h00);
    rd(2'd1, v); chk("R11 index untouched", v, 8'hA1);
    rd(2'd2, v); chk("R11 offset 2 reads zero", v, 8'h00);
    rd(2'd0, v); chk("R11 aux untouched", v, 8'h00);
    rd(2'd1, v); chk("R11 reg6 intact", v, 8'hB2);
    rd(2'd3, v); chk("R11 offset 3 reads zero", v, 8'h00);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end
endmodule